// File: doc/BRIEF.md
# Four-Byte Page Buffer with Self-Timed Commit

This block sits between a serial bus front end and a 256-byte storage array. A write transaction opens with a word address. The data bytes that follow are gathered into a small page buffer that holds four bytes and is aligned on a four-byte boundary. Each slot in the buffer has a valid flag. When the front end reports the end of the transaction, the block copies the received bytes into the array, one slot per clock. It then keeps a busy flag high for a programmable number of system clocks, which models the self-timed programming period.

While the busy flag is high, the block ignores every request from the front end, and the front end is expected to stay silent on the bus. The array has a registered read port that the front end uses to serve read transfers. The busy length is a parameter in clock cycles. At a 250 MHz system clock, the default of 1,250,000 cycles gives about 5 ms, and a testbench can shorten it.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy` is low and every storage location reads as 0x00.
- R2: `txn_start` records `txn_addr`. The first data byte goes to `txn_addr`, and each further byte goes to the next address up. The page is selected by `txn_addr[7:2]` and the byte within the page by `txn_addr[1:0]`.
- R3: The address advance affects only bits [1:0], so a byte past offset 3 wraps to offset 0 of the same page. A fifth byte replaces the first byte buffered.
- R4: A commit writes only the slots that received a byte. The other three bytes of the page keep their earlier contents.
- R5: A `commit_req` that is accepted while at least one slot is valid raises `busy` in the next cycle. `busy` then stays high for exactly `BUSY_CYCLES` consecutive cycles.
- R6: A `commit_req` with no valid slot starts no write cycle. `busy` stays low and storage is unchanged.
- R7: While `busy` is high, `txn_start`, `byte_valid` and `commit_req` have no effect on the buffer, the storage array or the busy timing.
- R8: The valid flags are cleared when a new transaction opens and when a commit finishes. Bytes from an earlier transaction that was never committed, or from one already committed, are not written again.
- R9: `rd_data` shows the contents at `rd_addr` one clock after `rd_addr` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Opens a write transaction and records its word address |
| txn_addr | input | 8 | Word address of the first data byte |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Received data byte |
| commit_req | input | 1 | End of transaction: copy the buffered bytes into storage |
| rd_addr | input | 8 | Read address of the storage array |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Write cycle in progress; the front end must stay silent |

## Verification
A wrong write pointer or a wrong page base places a byte at the wrong address, or fails to wrap it. This can be seen once the commit has finished, as soon as the neighbouring addresses of the page are read back. A stale valid flag shows up as an untouched address that changes value, or as a busy period after a commit that should have done nothing. In both cases the fault is visible on the first read, or the first cycle after `commit_req`. A fault in the timer or the state sequencer changes the busy length by at least one cycle, and this is measured on every commit.

// File: rtl/pcu_pkg.sv
// Package: pcu_pkg
// Shared types of the page commit unit.
// Assumes: nothing beyond the standard language.
package pcu_pkg;

    // Commit sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,   // accepting bytes and commit requests
        SEQ_WRITE = 2'd1,   // copying buffer slots into storage, one per cycle
        SEQ_HOLD  = 2'd2    // waiting for the busy timer to expire
    } seq_state_t;

endpackage

// File: rtl/page_buffer.sv
// Module: page_buffer
// Holds one page of PAGE_BYTES data bytes, a valid flag per slot, the page
// base address and a write pointer that wraps inside the page.
// Assumes: open_i and push_i are already gated by the caller while busy;
// open_i has priority over push_i in the same cycle; clear_i never
// coincides with open_i.
module page_buffer #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    open_i,
    input  logic [ADDR_W-1:0]       open_addr_i,
    input  logic                    push_i,
    input  logic [DATA_W-1:0]       push_data_i,
    input  logic                    clear_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot_i,
    output logic [ADDR_W-1:0]       page_base_o,
    output logic [PAGE_BYTES-1:0]   mask_o,
    output logic [DATA_W-1:0]       slot_data_o
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0]     base_q;
    logic [SLOT_W-1:0]     ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    // Record the page base and starting slot when a transaction opens
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (open_i) begin
            base_q <= {open_addr_i[ADDR_W-1:SLOT_W], {SLOT_W{1'b0}}};
        end
    end

    // Write pointer: loaded on open, advanced modulo the page on each byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (open_i) begin
            ptr_q <= open_addr_i[SLOT_W-1:0];
        end else if (push_i) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Valid flags: cleared on open and after a commit, set per received byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (open_i || clear_i) begin
            mask_q <= '0;
        end else if (push_i) begin
            mask_q[ptr_q] <= 1'b1;
        end
    end

    // One data register per slot, loaded when the pointer selects it
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[s] <= '0;
            end else if (push_i && !open_i && (ptr_q == SLOT_W'(s))) begin
                data_q[s] <= push_data_i;
            end
        end
    end

    // Expose the buffered state to the sequencer
    always_comb begin
        page_base_o = base_q;
        mask_o      = mask_q;
        slot_data_o = data_q[rd_slot_i];
    end

endmodule

// File: rtl/busy_timer.sv
// Module: busy_timer
// Down-counter that measures the self-timed write cycle. Loaded with
// BUSY_CYCLES-1 on start; done_o is high while the count is zero.
// Assumes: BUSY_CYCLES >= 1; start_i is only pulsed while the count is idle.
module busy_timer #(
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero count means the programmed period has elapsed
    always_comb begin
        done_o = (cnt_q == '0);
    end

endmodule

// File: rtl/commit_sequencer.sv
// Module: commit_sequencer
// Accepts a commit when at least one slot is valid. It walks every slot of
// the page, issuing a storage write for each valid one, then waits for the
// busy timer. busy_o covers the whole sequence.
// Assumes: the busy timer is longer than the slot walk (BUSY_CYCLES > PAGE_BYTES).
module commit_sequencer
    import pcu_pkg::*;
#(
    parameter int PAGE_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [PAGE_BYTES-1:0]   mask_i,
    input  logic                    timer_done_i,
    output logic [$clog2(PAGE_BYTES)-1:0] slot_o,
    output logic                    we_o,
    output logic                    timer_start_o,
    output logic                    clear_o,
    output logic                    busy_o
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

    seq_state_t        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic              accept;

    // A commit is taken only in idle and only with something to write
    always_comb begin
        accept = (state_q == SEQ_IDLE) && commit_i && (|mask_i);
    end

    // Phase register: idle -> write walk -> hold -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE:  if (accept) state_q <= SEQ_WRITE;
                SEQ_WRITE: if (slot_q == LAST_SLOT) state_q <= SEQ_HOLD;
                SEQ_HOLD:  if (timer_done_i) state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Slot walk counter, restarted at zero on each accepted commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (accept) begin
            slot_q <= '0;
        end else if (state_q == SEQ_WRITE) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Control outputs derived from the phase
    always_comb begin
        slot_o        = slot_q;
        we_o          = (state_q == SEQ_WRITE) && mask_i[slot_q];
        timer_start_o = accept;
        clear_o       = (state_q == SEQ_HOLD) && timer_done_i;
        busy_o        = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/storage_array.sv
// Module: storage_array
// 2**ADDR_W x DATA_W storage with one write port and one registered read
// port. Synchronous reset clears every location. A read in the same cycle
// as a write to that address returns the old value.
// Assumes: single clock domain.
module storage_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Cell contents: cleared on reset, written when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    // Drive the read result
    always_comb begin
        rdata_o = rdata_q;
    end

endmodule

// File: rtl/page_commit_unit.sv
// Module: page_commit_unit (top)
// Gathers data bytes into a four-byte page buffer, commits the valid ones
// into the storage array, then holds busy for BUSY_CYCLES clocks. While
// busy, all front-end requests are dropped.
// Assumes: BUSY_CYCLES > PAGE_BYTES; the front end presents commit_req only
// after its last byte_valid cycle.
module page_commit_unit #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);

    if (BUSY_CYCLES <= PAGE_BYTES) begin : g_bad_busy
        $error("BUSY_CYCLES must exceed PAGE_BYTES");
    end

    logic                  busy_w;
    logic                  open_g, push_g, commit_g;
    logic [ADDR_W-1:0]     page_base;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     slot_data;
    logic [SLOT_W-1:0]     slot;
    logic                  mem_we;
    logic                  timer_start, timer_done, clear_mask;
    logic [ADDR_W-1:0]     wr_addr;

    // Drop every front-end request while a write cycle runs
    always_comb begin
        open_g   = txn_start  && !busy_w;
        push_g   = byte_valid && !busy_w && !txn_start;
        commit_g = commit_req && !busy_w;
        wr_addr  = {page_base[ADDR_W-1:SLOT_W], slot};
        busy     = busy_w;
    end

    page_buffer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (open_g),
        .open_addr_i (txn_addr),
        .push_i      (push_g),
        .push_data_i (byte_data),
        .clear_i     (clear_mask),
        .rd_slot_i   (slot),
        .page_base_o (page_base),
        .mask_o      (mask),
        .slot_data_o (slot_data)
    );

    commit_sequencer #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit_g),
        .mask_i        (mask),
        .timer_done_i  (timer_done),
        .slot_o        (slot),
        .we_o          (mem_we),
        .timer_start_o (timer_start),
        .clear_o       (clear_mask),
        .busy_o        (busy_w)
    );

    busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (timer_start),
        .done_o  (timer_done)
    );

    storage_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (wr_addr),
        .wdata_i (slot_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/page_commit_checker.sv
// Module: page_commit_checker
// Concurrent properties on the page commit unit, attached by bind.
// Assumes: connected to the top-level ports and to the buffer's base and mask.
module page_commit_checker #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int BUSY_CYCLES = 1250000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  commit_req,
    input logic [PAGE_BYTES-1:0] mask,
    input logic [ADDR_W-1:0]     page_base,
    input logic                  mem_we
);

    logic [31:0] run_len;

    // Count consecutive busy cycles for the duration check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= '0;
        end
    end

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_req));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(BUSY_CYCLES)));

    // R6
    empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !busy && (mask == '0)) |=> !busy);

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_base));

    // R7
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mask == '0));

endmodule

bind page_commit_unit page_commit_checker #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .commit_req (commit_req),
    .mask       (mask),
    .page_base  (page_base),
    .mem_we     (mem_we)
);

// File: tb/test_page_commit_unit.sv
// Scoreboard bench: driver tasks push expected read items into a queue,
// a monitor pops and compares them one clock after each read is issued.
`timescale 1ns/1ps
module test_page_commit_unit;

    localparam int BUSY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic [7:0] txn_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       commit_req = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    // independent model
    logic [7:0] model_mem [256];
    logic [7:0] pend_data [4];
    logic [3:0] pend_mask;
    logic [7:0] pend_base;
    logic [1:0] pend_ptr;

    always #2 clk = ~clk;

    page_commit_unit #(.BUSY_CYCLES(BUSY)) i_page_commit_unit (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .commit_req(commit_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares the read result one clock after the address was driven
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(rd_data === it.data, it.req, int'(rd_data), int'(it.data));
        end
    end

    task automatic read_exp(input logic [7:0] a, input string req);
        exp_t it;
        @(negedge clk);
        rd_addr = a;
        it.addr = a; it.data = model_mem[a]; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic open_txn(input logic [7:0] a);
        @(negedge clk);
        txn_start = 1'b1; txn_addr = a;
        @(negedge clk);
        txn_start = 1'b0;
        pend_base = {a[7:2], 2'b00}; pend_ptr = a[1:0]; pend_mask = '0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
        pend_data[pend_ptr] = d; pend_mask[pend_ptr] = 1'b1; pend_ptr = pend_ptr + 1'b1;
    endtask

    // Issue commit, check busy start and length; optional requests during busy
    task automatic do_commit(input bit expect_write, input bit noise, input string req);
        int n;
        @(negedge clk);
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
        check(busy === expect_write, req, int'(busy), int'(expect_write));
        if (expect_write) begin
            n = 1;
            while (n < BUSY + 10) begin
                if (noise && n == 3) begin
                    txn_start = 1'b1; txn_addr = 8'h90;
                    byte_valid = 1'b1; byte_data = 8'h77; commit_req = 1'b1;
                end
                @(negedge clk);
                txn_start = 1'b0; byte_valid = 1'b0; commit_req = 1'b0;
                if (!busy) break;
                n++;
            end
            check(n == BUSY, req, n, BUSY);
            for (int s = 0; s < 4; s++)
                if (pend_mask[s]) model_mem[pend_base + s] = pend_data[s];
            pend_mask = '0;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
        pend_mask = '0; pend_base = '0; pend_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        read_exp(8'h00, "R1 reset content");
        read_exp(8'hFF, "R1 reset content");
        read_exp(8'h10, "R9 read latency");
        drain();

        // R2 consecutive bytes from aligned start, R5 busy timing
        open_txn(8'h10);
        send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
        do_commit(1'b1, 1'b0, "R5 busy start/length");
        for (int a = 8'h10; a < 8'h14; a++) read_exp(8'(a), "R2 page write");
        drain();

        // R3 wrap from offset 2, R4 untouched slot keeps content
        open_txn(8'h22);
        send_byte(8'hB2); send_byte(8'hB3); send_byte(8'hB0);
        do_commit(1'b1, 1'b0, "R5 busy start/length");
        read_exp(8'h20, "R3 wrap to page start");
        read_exp(8'h21, "R4 unwritten slot");
        read_exp(8'h22, "R2 first byte at start address");
        read_exp(8'h23, "R2 second byte");
        read_exp(8'h24, "R3 no spill to next page");
        drain();

        // R4 preserve old content: partial rewrite of page 0x10
        open_txn(8'h11);
        send_byte(8'hC1);
        do_commit(1'b1, 1'b0, "R5 busy start/length");
        for (int a = 8'h10; a < 8'h14; a++) read_exp(8'(a), "R4 partial commit");
        drain();

        // R3 fifth byte overwrites the first
        open_txn(8'h41);
        send_byte(8'hD1); send_byte(8'hD2); send_byte(8'hD3); send_byte(8'hD0); send_byte(8'hDF);
        do_commit(1'b1, 1'b0, "R5 busy start/length");
        for (int a = 8'h40; a < 8'h44; a++) read_exp(8'(a), "R3 fifth byte overwrite");
        drain();

        // R6 commit with nothing buffered; R8 mask cleared after commit
        do_commit(1'b0, 1'b0, "R8 no rewrite after commit");
        open_txn(8'h50);
        do_commit(1'b0, 1'b0, "R6 empty commit");
        read_exp(8'h50, "R6 storage unchanged");
        drain();

        // R7 requests during busy are ignored
        open_txn(8'h80);
        send_byte(8'h55);
        do_commit(1'b1, 1'b1, "R7 busy length with noise");
        do_commit(1'b0, 1'b0, "R7 no byte buffered by noise");
        read_exp(8'h80, "R7 committed byte");
        read_exp(8'h81, "R7 neighbour untouched");
        read_exp(8'h90, "R7 noise address untouched");
        read_exp(8'h91, "R7 noise address untouched");
        drain();

        // R8 a new transaction discards uncommitted bytes
        open_txn(8'h60);
        send_byte(8'h11); send_byte(8'h22);
        open_txn(8'h64);
        send_byte(8'h33);
        do_commit(1'b1, 1'b0, "R8 commit after reopen");
        read_exp(8'h60, "R8 abandoned byte not written");
        read_exp(8'h61, "R8 abandoned byte not written");
        read_exp(8'h64, "R8 new byte written");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule